// File: doc/BRIEF.md
# Flash Parameter List Readout Sequencer

This block serves the "report geometry" command of a flash controller. Once the command is accepted, a result port presents a list of 32-bit words that describe the memory. Each read strobe on the result port moves to the next word. The list holds an interface identifier, the total size in bytes, the page size in bytes and the number of planes. Then come the byte size of each plane in plane order, the number of lock bits, and the byte size of each lock region. The length of the list therefore depends on the plane count and the lock-region count.

The geometry is fixed at elaboration through parameters. There can be up to four planes, each with its own size, and up to 32 lock regions of equal size. The lock-region size is the total size divided by the region count. After the last word has been consumed, the result port reads zero until a fresh command arrives. Decoding of the command keyword and access to the array itself happen elsewhere.

Top module: `fdr_desc_seq`

## Requirements
- R1: After synchronous reset, and before any command, `res_word` is 0 and `res_ready` is 1. Read strobes in this state leave `res_word` at 0.
- R2: A `desc_start` pulse drives `res_ready` low for exactly the one cycle after the sampling edge. `res_ready` is high again from the following cycle.
- R3: Right after a command, `res_word` shows word 0, the interface identifier `IFACE_ID`. Accepted reads then give word 1, the total size (sum of the used plane sizes), word 2, `PAGE_BYTES`, and word 3, `PLANE_CNT`.
- R4: Words 4 to 3+`PLANE_CNT` give the plane sizes from `PLANE_SIZES[0]` upward, one word per plane.
- R5: Word 4+`PLANE_CNT` gives `LOCK_CNT`, the number of lock bits.
- R6: The next `LOCK_CNT` words each give the lock-region size, which is the total size divided by `LOCK_CNT`.
- R7: A read accepted while the last word is shown makes `res_word` 0. Further reads keep it at 0 until the next command.
- R8: A command issued partway through the list restarts it at word 0.
- R9: A read strobe in the cycle where `res_ready` is low is ignored, and the word index does not move.
- R10: When `desc_start` and `res_rd` are sampled on the same edge, the command wins and word 0 is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| desc_start | input | 1 | One-cycle strobe: a descriptor command was accepted |
| res_rd | input | 1 | One-cycle strobe: the result word was read |
| res_word | output | 32 | Current result word, 0 when no list is active |
| res_ready | output | 1 | Low for one cycle after a command, high otherwise |

## Verification
The result word and the ready flag both change on the edge that samples a strobe. There is no further register stage, so the new word and the ready state can be checked half a cycle after that edge. The driver applies each strobe for exactly one edge and queues the expected word or flag. The monitor pops and compares that entry on the next falling edge, so every comparison lands in the cycle the design is due to change. The stimulus covers a full walk of the list, reads after the end, a restart partway through, a read during the ready-low cycle, and a command that collides with a read.

// File: rtl/fdr_pkg.sv
// Package: shared word type, geometry limits and helpers for the
// descriptor readout sequencer. Assumes plane sizes fit in 32 bits.
package fdr_pkg;

    localparam int unsigned FDR_MAX_PLANES = 4;
    localparam int unsigned FDR_MAX_LOCKS  = 32;
    localparam int unsigned FDR_FIXED_HEAD = 4;   // id, size, page, planes

    typedef logic [31:0] fdr_word_t;
    typedef logic [FDR_MAX_PLANES-1:0][31:0] fdr_plane_sizes_t;

    // Number of words in the whole list for a given geometry.
    function automatic int unsigned fdr_word_count(int unsigned planes, int unsigned locks);
        return FDR_FIXED_HEAD + planes + 1 + locks;
    endfunction

    // Sum of the first 'planes' plane sizes.
    function automatic fdr_word_t fdr_total_bytes(fdr_plane_sizes_t sizes, int unsigned planes);
        fdr_word_t acc;
        acc = '0;
        for (int unsigned i = 0; i < FDR_MAX_PLANES; i++) begin
            if (i < planes) acc = acc + sizes[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/fdr_ready_ctl.sv
// Ready flag control. Drops the flag for the single cycle after a
// command edge and holds it high otherwise. Assumes desc_start is a
// one-cycle strobe.
module fdr_ready_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic desc_start,
    output logic ready
);

    // Register the ready flag: low only right after a command.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b1;
        else        ready <= !desc_start;
    end

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        desc_start |=> !ready);
    a_r2_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !desc_start) |=> ready);

endmodule

// File: rtl/fdr_index_ctr.sv
// Word index and activity tracking. A command clears the index and marks
// the list active. An accepted read (ready high, active, no command)
// steps the index by one, and accepting the last word ends the list.
module fdr_index_ctr #(
    parameter int unsigned WORDS = 15,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_start,
    input  logic          res_rd,
    input  logic          ready,
    output logic [IW-1:0] idx,
    output logic          active,
    output logic          take_last
);

    localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

    logic take;

    // Decide whether this edge consumes a word.
    always_comb begin
        take      = res_rd && ready && active && !desc_start;
        take_last = take && (idx == LAST_IDX);
    end

    // Index register: cleared by a command, stepped by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx <= '0;
        else if (desc_start) idx <= '0;
        else if (take && !take_last) idx <= idx + 1'b1;
    end

    // Activity register: set by a command, cleared after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n)          active <= 1'b0;
        else if (desc_start) active <= 1'b1;
        else if (take_last)  active <= 1'b0;
    end

    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        desc_start |=> (idx == '0 && active));
    a_r9_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !desc_start) |=> $stable(idx));
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && ready && active && !desc_start && idx != LAST_IDX)
        |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/fdr_word_gen.sv
// Word generator. Maps a word index onto the descriptor content computed
// from the geometry parameters: the fixed head, per-plane sizes, the lock
// count and the equal-sized lock regions. Purely combinational.
module fdr_word_gen
    import fdr_pkg::*;
#(
    parameter fdr_word_t        IFACE_ID    = 32'h0000_5A10,
    parameter fdr_word_t        PAGE_BYTES  = 32'd512,
    parameter int unsigned      PLANE_CNT   = 2,
    parameter fdr_plane_sizes_t PLANE_SIZES = {32'd0, 32'd0, 32'd32768, 32'd65536},
    parameter int unsigned      LOCK_CNT    = 8,
    localparam int unsigned     WORDS       = fdr_word_count(PLANE_CNT, LOCK_CNT),
    localparam int unsigned     IW          = $clog2(WORDS)
) (
    input  logic [IW-1:0] idx,
    output fdr_word_t     word
);

    localparam fdr_word_t     TOTAL      = fdr_total_bytes(PLANE_SIZES, PLANE_CNT);
    localparam fdr_word_t     REGION     = TOTAL / LOCK_CNT;
    localparam logic [IW-1:0] PLANE_BASE = IW'(FDR_FIXED_HEAD);
    localparam logic [IW-1:0] LOCK_IDX   = IW'(FDR_FIXED_HEAD + PLANE_CNT);

    logic [IW-1:0] plane_ofs;

    // Select the word that belongs to the current index.
    always_comb begin
        plane_ofs = idx - PLANE_BASE;
        word      = '0;
        if      (idx == IW'(0))    word = IFACE_ID;
        else if (idx == IW'(1))    word = TOTAL;
        else if (idx == IW'(2))    word = PAGE_BYTES;
        else if (idx == IW'(3))    word = fdr_word_t'(PLANE_CNT);
        else if (idx <  LOCK_IDX)  word = PLANE_SIZES[plane_ofs[1:0]];
        else if (idx == LOCK_IDX)  word = fdr_word_t'(LOCK_CNT);
        else                       word = REGION;
    end

endmodule

// File: rtl/fdr_desc_seq.sv
// Top of the descriptor readout sequencer. Ties the ready control, the
// index counter and the word generator together. The result is zero
// whenever no list is active. Assumes 1..4 planes and 1..32 lock regions.
module fdr_desc_seq
    import fdr_pkg::*;
#(
    parameter fdr_word_t        IFACE_ID    = 32'h0000_5A10,
    parameter fdr_word_t        PAGE_BYTES  = 32'd512,
    parameter int unsigned      PLANE_CNT   = 2,
    parameter fdr_plane_sizes_t PLANE_SIZES = {32'd0, 32'd0, 32'd32768, 32'd65536},
    parameter int unsigned      LOCK_CNT    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        desc_start,
    input  logic        res_rd,
    output logic [31:0] res_word,
    output logic        res_ready
);

    localparam int unsigned WORDS = fdr_word_count(PLANE_CNT, LOCK_CNT);
    localparam int unsigned IW    = $clog2(WORDS);

    logic [IW-1:0] idx;
    logic          active;
    logic          take_last;
    fdr_word_t     gen_word;

    fdr_ready_ctl u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_start (desc_start),
        .ready      (res_ready)
    );

    fdr_index_ctr #(.WORDS(WORDS)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_start (desc_start),
        .res_rd     (res_rd),
        .ready      (res_ready),
        .idx        (idx),
        .active     (active),
        .take_last  (take_last)
    );

    fdr_word_gen #(
        .IFACE_ID    (IFACE_ID),
        .PAGE_BYTES  (PAGE_BYTES),
        .PLANE_CNT   (PLANE_CNT),
        .PLANE_SIZES (PLANE_SIZES),
        .LOCK_CNT    (LOCK_CNT)
    ) u_word (
        .idx  (idx),
        .word (gen_word)
    );

    // Gate the generated word: zero outside an active list.
    always_comb begin
        res_word = active ? gen_word : '0;
    end

    a_r7_zero_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (take_last && !desc_start) |=> (res_word == '0));
    a_r3_head_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        desc_start |=> (res_word == IFACE_ID));
    a_r10_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_start && res_rd) |=> (res_word == IFACE_ID && !res_ready));

endmodule

// File: tb/fdr_desc_seq_test.sv
// Scoreboard bench: the driver queues expected items, and the monitor
// compares them on the falling edge after each strobe.
module fdr_desc_seq_test;

    localparam logic [31:0] ID    = 32'h0000_5A10;
    localparam logic [31:0] PAGE  = 32'd512;
    localparam logic [31:0] P0    = 32'd65536;
    localparam logic [31:0] P1    = 32'd32768;
    localparam logic [31:0] TOT   = 32'd98304;
    localparam logic [31:0] REG   = 32'd12288;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_start = 1'b0;
    logic        res_rd = 1'b0;
    logic [31:0] res_word;
    logic        res_ready;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_ready;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    fdr_desc_seq #(
        .IFACE_ID    (ID),
        .PAGE_BYTES  (PAGE),
        .PLANE_CNT   (2),
        .PLANE_SIZES ({32'd0, 32'd0, P1, P0}),
        .LOCK_CNT    (8)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_start (desc_start),
        .res_rd     (res_rd),
        .res_word   (res_word),
        .res_ready  (res_ready)
    );

    // Monitor: pop every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e = exp_q.pop_front();
            act = e.is_ready ? {31'd0, res_ready} : res_word;
            tests++;
            if (act !== e.val) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
            end
        end
    end

    task automatic push_word(logic [31:0] v, string tag);
        exp_t e;
        e.is_ready = 1'b0; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_ready(logic v, string tag);
        exp_t e;
        e.is_ready = 1'b1; e.val = {31'd0, v}; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Drive one edge with the given strobes, then release them.
    task automatic tick(bit c, bit r);
        desc_start = c;
        res_rd     = r;
        @(posedge clk);
        #1;
        desc_start = 1'b0;
        res_rd     = 1'b0;
    endtask

    task automatic wait_mon();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_word(32'd0, "R1 reset word");
        push_ready(1'b1, "R1 reset ready");
        wait_mon();
        tick(0, 1);
        push_word(32'd0, "R1 read before command");
        wait_mon();

        // Start and read the list right after the command.
        tick(1, 0);
        push_word(ID, "R3 word0 id");
        push_ready(1'b0, "R2 ready low after cmd");
        wait_mon();
        tick(0, 1);
        push_word(ID, "R9 read ignored while not ready");
        push_ready(1'b1, "R2 ready back high");
        wait_mon();

        tick(0, 1); push_word(TOT,   "R3 word1 total");  wait_mon();
        tick(0, 1); push_word(PAGE,  "R3 word2 page");   wait_mon();
        tick(0, 1); push_word(32'd2, "R3 word3 planes"); wait_mon();
        tick(0, 1); push_word(P0,    "R4 plane0 size");  wait_mon();
        tick(0, 1); push_word(P1,    "R4 plane1 size");  wait_mon();
        tick(0, 1); push_word(32'd8, "R5 lock count");   wait_mon();
        for (int i = 0; i < 8; i++) begin
            tick(0, 1); push_word(REG, "R6 region size"); wait_mon();
        end
        tick(0, 1); push_word(32'd0, "R7 zero after last"); wait_mon();
        tick(0, 1); push_word(32'd0, "R7 still zero");      wait_mon();
        tick(0, 0); push_word(32'd0, "R7 zero while idle"); wait_mon();

        // Restart partway through the list.
        tick(1, 0); push_word(ID, "R8 second command"); wait_mon();
        tick(0, 0);
        for (int i = 0; i < 4; i++) tick(0, 1);
        push_word(P0, "R4 plane0 on second pass");
        wait_mon();
        tick(1, 0); push_word(ID, "R8 restart mid list"); wait_mon();
        tick(0, 0);
        tick(0, 1); push_word(TOT, "R8 resumes at word1"); wait_mon();

        // Command colliding with a read.
        tick(1, 1);
        push_word(ID, "R10 cmd beats read");
        push_ready(1'b0, "R10 ready low on collision");
        wait_mon();
        tick(0, 0);
        tick(0, 1); push_word(TOT, "R10 next read gives word1"); wait_mon();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule